// File: doc/BRIEF.md
# Parallel Flash Command Mode Controller

This block is the behavioural command front end of a parallel NOR-style flash. Active-low chip-enable, output-enable and write-enable strobes, an 11-bit word address and a 16-bit data bus are sampled on a system clock. From these it recognises read cycles and command write cycles. It tracks the device mode: read-array, the unlock steps, autoselect, unlock-bypass, and busy while a program runs. The read data comes from a small on-chip word array, from an identification register, or from a status byte. The output driver is enabled only during a qualified read cycle.

Programming works the way a NOR cell does: bits can only go from 1 to 0. The stored word becomes the AND of the old word and the programmed data. The busy time is a fixed number of clock cycles set by a parameter. While busy, reads return a status byte instead of array data. Chip enable may be released during that time and the program still completes. In the unlock-bypass mode a program needs two write cycles instead of four.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the mode is read-array and the array holds all ones, so a read of any address returns 0xFFFF without any command.
- R2: A read cycle (ce_n=0, oe_n=0, we_n=1) drives dq_oe=1, and dq_out shows the selected data in the same cycle the strobes are applied.
- R3: One command write is accepted per falling edge of we_n seen while ce_n=0 and oe_n=1. Holding we_n low for several cycles is still one write. we_n low while oe_n=0 is not a write.
- R4: A standard program is 0xAA to address 0x555, then 0x55 to 0x2AA, then 0xA0 to 0x555, then a write of data to the target address. The array word at address bits 5..0 becomes old AND data.
- R5: In the unlock steps, any write that does not match the expected address and low data byte returns the controller to read-array.
- R6: The sequence AA/55 followed by 0x90 at 0x555 enters autoselect. In autoselect, reads at address bits 1..0 = 0 return MANUF_CODE, = 1 return DEVICE_CODE, and otherwise return 0, all with upper byte 0. A write of 0xF0 returns to read-array.
- R7: After the program data write the controller stays busy for exactly BUSY_CYCLES clock cycles. Writes during busy are ignored. Releasing ce_n does not stop the operation.
- R8: While busy, reads return 0x00 in bits 15..8 and the complement of programmed data bit 7 in bit 7. Bit 6 inverts at the start of each read, and the first read after the program starts shows 1. Bits 5..0 are 0.
- R9: The sequence AA/55 followed by 0x20 at 0x555 enters bypass. In bypass, 0xA0 to any address followed by a data write programs. After busy the controller returns to bypass.
- R10: In bypass, 0x90 followed by 0x00 returns to read-array. 0x90 followed by any other byte stays in bypass.
- R11: dq_oe is 0 and dq_out is 0 whenever ce_n=1, oe_n=1 or we_n=0.
- R12: 0xF0 written in read-array, or as the third unlock cycle, leaves the controller in read-array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Word address |
| dq_in | input | 16 | Data written by the host |
| dq_out | output | 16 | Read data (array, identification or status) |
| dq_oe | output | 1 | Output driver enable; 0 means high impedance |

## Verification
The assertions assume the strobes are synchronous to clk and stay stable for at least one clock between changes, so each falling edge of we_n is seen by exactly one sample. They also assume the host does not need the busy time to be interruptible. The bench drives every strobe and bus change on the falling clock edge and holds each level for at least one full cycle. It never mixes a low we_n with a low oe_n except in the one case that checks such a cycle is rejected. It also waits more than BUSY_CYCLES before it expects array data back.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        M_READ,
        M_UNL1,
        M_UNL2,
        M_PGM,
        M_AUTOSEL,
        M_BYP,
        M_BYP_PGM,
        M_BYP_EXIT,
        M_BUSY
    } mode_e;

    localparam logic [10:0] UNLOCK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLOCK_ADDR_B = 11'h2AA;

    localparam logic [7:0] KEY_FIRST    = 8'hAA;
    localparam logic [7:0] KEY_SECOND   = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_BYPASS   = 8'h20;
    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_BYP_QUIT = 8'h00;

endpackage

// File: rtl/flash_strobe_decode.sv
`timescale 1ns/1ps
module flash_strobe_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_ev,
    output logic rd_act,
    output logic rd_start
);

    typedef struct packed {
        logic we_n;
        logic rd;
    } strb_t;

    strb_t s_d, s_q;

    always_comb begin
        rd_act   = !ce_n && !oe_n && we_n;
        wr_ev    = !ce_n && !we_n && oe_n && s_q.we_n;
        rd_start = rd_act && !s_q.rd;
        s_d.we_n = we_n;
        s_d.rd   = rd_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.we_n <= 1'b1;
            s_q.rd   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: a single low phase of we_n yields one write event only
    assert_single_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ev |=> !wr_ev);

endmodule

// File: rtl/flash_cmd_fsm.sv
`timescale 1ns/1ps
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 16,
    parameter int ARR_AW      = 6,
    parameter int BUSY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ev,
    input  logic              rd_start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output mode_e             mode_o,
    output logic              pgm_we,
    output logic [ARR_AW-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              tog_o,
    output logic              pd7_o
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        mode_e              mode;
        logic               ret_byp;
        logic [CNT_W-1:0]   cnt;
        logic [ARR_AW-1:0]  paddr;
        logic [DATA_W-1:0]  pdata;
        logic               tog;
    } fsm_t;

    fsm_t f_d, f_q;

    logic [7:0]  key;
    logic        at_a, at_b;

    always_comb begin
        key    = din[7:0];
        at_a   = (addr[10:0] == UNLOCK_ADDR_A);
        at_b   = (addr[10:0] == UNLOCK_ADDR_B);
        f_d    = f_q;
        pgm_we = 1'b0;
        case (f_q.mode)
            M_READ: begin
                if (wr_ev && at_a && key == KEY_FIRST) f_d.mode = M_UNL1;
            end
            M_UNL1: begin
                if (wr_ev) f_d.mode = (at_b && key == KEY_SECOND) ? M_UNL2 : M_READ;
            end
            M_UNL2: begin
                if (wr_ev) begin
                    f_d.mode = M_READ;
                    if (at_a) begin
                        case (key)
                            CMD_PROGRAM: f_d.mode = M_PGM;
                            CMD_IDENT:   f_d.mode = M_AUTOSEL;
                            CMD_BYPASS:  f_d.mode = M_BYP;
                            default:     f_d.mode = M_READ;
                        endcase
                    end
                end
            end
            M_PGM, M_BYP_PGM: begin
                if (wr_ev) begin
                    f_d.mode    = M_BUSY;
                    f_d.ret_byp = (f_q.mode == M_BYP_PGM);
                    f_d.cnt     = CNT_W'(BUSY_CYCLES - 1);
                    f_d.paddr   = addr[ARR_AW-1:0];
                    f_d.pdata   = din;
                    f_d.tog     = 1'b0;
                end
            end
            M_AUTOSEL: begin
                if (wr_ev && key == CMD_RESET) f_d.mode = M_READ;
            end
            M_BYP: begin
                if (wr_ev) begin
                    if (key == CMD_PROGRAM)    f_d.mode = M_BYP_PGM;
                    else if (key == CMD_IDENT) f_d.mode = M_BYP_EXIT;
                end
            end
            M_BYP_EXIT: begin
                if (wr_ev) f_d.mode = (key == CMD_BYP_QUIT) ? M_READ : M_BYP;
            end
            M_BUSY: begin
                if (rd_start) f_d.tog = ~f_q.tog;
                if (f_q.cnt == '0) begin
                    pgm_we   = 1'b1;
                    f_d.mode = f_q.ret_byp ? M_BYP : M_READ;
                end else begin
                    f_d.cnt = f_q.cnt - CNT_W'(1);
                end
            end
            default: f_d.mode = M_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.mode    <= M_READ;
            f_q.ret_byp <= 1'b0;
            f_q.cnt     <= '0;
            f_q.paddr   <= '0;
            f_q.pdata   <= '0;
            f_q.tog     <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign mode_o   = f_q.mode;
    assign pgm_addr = f_q.paddr;
    assign pgm_data = f_q.pdata;
    assign tog_o    = f_q.tog;
    assign pd7_o    = f_q.pdata[7];

    // R7: busy persists while the countdown is non-zero, whatever is written
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.mode == M_BUSY && f_q.cnt != '0) |=> (f_q.mode == M_BUSY));

    // R7: busy ends on the cycle after the countdown reaches zero
    assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.mode == M_BUSY && f_q.cnt == '0) |=> (f_q.mode != M_BUSY));

    // R8: each new read while busy inverts the toggle bit
    assert_status_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.mode == M_BUSY && rd_start) |=> (f_q.tog != $past(f_q.tog)));

    // R9: a program command in bypass arms the two-cycle program
    assert_bypass_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.mode == M_BYP && wr_ev && din[7:0] == CMD_PROGRAM) |=> (f_q.mode == M_BYP_PGM));

endmodule

// File: rtl/flash_word_array.sv
`timescale 1ns/1ps
module flash_word_array #(
    parameter int ARR_AW = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ARR_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ARR_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ARR_AW;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = mem_q[waddr] & wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

    // R4: programming only clears bits; no bit outside the data pattern survives as 1
    assert_and_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem_q[$past(waddr)] & ~$past(wdata)) == '0));

endmodule

// File: rtl/flash_read_mux.sv
`timescale 1ns/1ps
module flash_read_mux
    import flash_cmd_pkg::*;
#(
    parameter int         DATA_W      = 16,
    parameter logic [7:0] MANUF_CODE  = 8'h5A,
    parameter logic [7:0] DEVICE_CODE = 8'hB3
) (
    input  mode_e             mode,
    input  logic              out_en,
    input  logic [1:0]        addr_lo,
    input  logic [DATA_W-1:0] rdata,
    input  logic              tog,
    input  logic              pd7,
    output logic [DATA_W-1:0] data_o
);

    always_comb begin
        data_o = '0;
        if (out_en) begin
            case (mode)
                M_BUSY:    data_o = DATA_W'({~pd7, tog, 6'b000000});
                M_AUTOSEL: begin
                    case (addr_lo)
                        2'd0:    data_o = DATA_W'(MANUF_CODE);
                        2'd1:    data_o = DATA_W'(DEVICE_CODE);
                        default: data_o = '0;
                    endcase
                end
                default:   data_o = rdata;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W      = 11,
    parameter int         DATA_W      = 16,
    parameter int         ARR_AW      = 6,
    parameter int         BUSY_CYCLES = 64,
    parameter logic [7:0] MANUF_CODE  = 8'h5A,
    parameter logic [7:0] DEVICE_CODE = 8'hB3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic              wr_ev, rd_act, rd_start;
    mode_e             mode;
    logic              pgm_we, tog, pd7;
    logic [ARR_AW-1:0] pgm_addr;
    logic [DATA_W-1:0] pgm_data, rdata;

    flash_strobe_decode i_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .wr_ev    (wr_ev),
        .rd_act   (rd_act),
        .rd_start (rd_start)
    );

    flash_cmd_fsm #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .ARR_AW      (ARR_AW),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ev    (wr_ev),
        .rd_start (rd_start),
        .addr     (addr),
        .din      (dq_in),
        .mode_o   (mode),
        .pgm_we   (pgm_we),
        .pgm_addr (pgm_addr),
        .pgm_data (pgm_data),
        .tog_o    (tog),
        .pd7_o    (pd7)
    );

    flash_word_array #(
        .ARR_AW (ARR_AW),
        .DATA_W (DATA_W)
    ) i_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pgm_we),
        .waddr (pgm_addr),
        .wdata (pgm_data),
        .raddr (addr[ARR_AW-1:0]),
        .rdata (rdata)
    );

    flash_read_mux #(
        .DATA_W      (DATA_W),
        .MANUF_CODE  (MANUF_CODE),
        .DEVICE_CODE (DEVICE_CODE)
    ) i_mux (
        .mode    (mode),
        .out_en  (rd_act),
        .addr_lo (addr[1:0]),
        .rdata   (rdata),
        .tog     (tog),
        .pd7     (pd7),
        .data_o  (dq_out)
    );

    assign dq_oe = rd_act;

    // R11: outputs are released whenever the part is deselected or output is disabled
    assert_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!dq_oe && dq_out == '0));

endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;

    localparam int         BUSY = 20;
    localparam logic [7:0] MAN  = 8'h5A;
    localparam logic [7:0] DEV  = 8'hB3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(
        .BUSY_CYCLES (BUSY),
        .MANUF_CODE  (MAN),
        .DEVICE_CODE (DEV)
    ) i_flash_cmd_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .addr   (addr),
        .dq_in  (dq_in),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    // mode codes: 0 read, 1 first key, 2 second key, 3 program armed, 4 ident,
    // 5 bypass, 6 bypass program armed, 7 bypass exit pending, 8 busy
    int          m_mode;
    logic [15:0] m_mem [64];
    int          m_cnt;
    logic        m_ret, m_tog, m_pwe, m_prd;
    logic [5:0]  m_pa;
    logic [15:0] m_pd;

    always @(posedge clk) begin
        logic wr, rd, rs;
        logic [7:0] d;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_ret = 0; m_tog = 0; m_pwe = 1; m_prd = 0;
            m_pa = '0; m_pd = '0;
            for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
        end else begin
            wr = !ce_n && !we_n && oe_n && m_pwe;
            rd = !ce_n && !oe_n && we_n;
            rs = rd && !m_prd;
            m_pwe = we_n;
            m_prd = rd;
            d = dq_in[7:0];
            if (m_mode == 8) begin
                if (rs) m_tog = !m_tog;
                m_cnt--;
                if (m_cnt == 0) begin
                    m_mem[m_pa] = m_mem[m_pa] & m_pd;
                    m_mode = m_ret ? 5 : 0;
                end
            end else if (wr) begin
                case (m_mode)
                    0: if (addr == 11'h555 && d == 8'hAA) m_mode = 1;
                    1: m_mode = (addr == 11'h2AA && d == 8'h55) ? 2 : 0;
                    2: begin
                        if (addr == 11'h555 && d == 8'hA0)      m_mode = 3;
                        else if (addr == 11'h555 && d == 8'h90) m_mode = 4;
                        else if (addr == 11'h555 && d == 8'h20) m_mode = 5;
                        else                                    m_mode = 0;
                    end
                    3, 6: begin
                        m_ret = (m_mode == 6);
                        m_cnt = BUSY; m_pa = addr[5:0]; m_pd = dq_in; m_tog = 0;
                        m_mode = 8;
                    end
                    4: if (d == 8'hF0) m_mode = 0;
                    5: begin
                        if (d == 8'hA0)      m_mode = 6;
                        else if (d == 8'h90) m_mode = 7;
                    end
                    7: m_mode = (d == 8'h00) ? 0 : 5;
                    default: m_mode = 0;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(posedge clk) begin
        logic        eo;
        logic [15:0] ev;
        string       tag;
        #1;
        if (rst_n) begin
            eo = !ce_n && !oe_n && we_n;
            ev = '0;
            tag = "R11";
            if (eo) begin
                if (m_mode == 8) begin
                    ev = {8'h00, ~m_pd[7], m_tog, 6'b0}; tag = "R8";
                end else if (m_mode == 4) begin
                    tag = "R6";
                    ev = (addr[1:0] == 2'd0) ? {8'h00, MAN} :
                         (addr[1:0] == 2'd1) ? {8'h00, DEV} : 16'h0000;
                end else begin
                    ev = m_mem[addr[5:0]]; tag = "R2";
                end
            end
            check(tag, {15'b0, dq_oe, dq_out}, {15'b0, eo, ev});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_write(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk); ce_n = 0; oe_n = 1; addr = a; dq_in = d; we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic do_read(input logic [10:0] a, output logic [16:0] v);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        @(posedge clk); #1; v = {dq_oe, dq_out};
        @(negedge clk); ce_n = 1; oe_n = 1;
    endtask

    task automatic unlock(input logic [7:0] cmd);
        do_write(11'h555, 16'h00AA);
        do_write(11'h2AA, 16'h0055);
        do_write(11'h555, {8'h00, cmd});
    endtask

    task automatic expect_read(input string tag, input logic [10:0] a, input logic [15:0] e);
        logic [16:0] v;
        do_read(a, v);
        check(tag, 32'(v), 32'({1'b1, e}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [16:0] v;
        repeat (4) @(negedge clk);
        check("R11 reset", {31'b0, dq_oe}, 32'd0);
        rst_n = 1;

        // R1: erased array readable without command
        expect_read("R1", 11'h005, 16'hFFFF);

        // R4: standard four-cycle program, with R8 status reads while busy
        unlock(8'hA0);
        do_write(11'h005, 16'h1234);
        do_read(11'h005, v);
        check("R8 first status", 32'(v), 32'({1'b1, 16'h00C0}));
        do_read(11'h005, v);
        check("R8 second status", 32'(v), 32'({1'b1, 16'h0080}));
        // R7: write during busy is ignored
        do_write(11'h555, 16'h00AA);
        repeat (BUSY + 5) @(negedge clk);
        expect_read("R4 program", 11'h005, 16'h1234);
        do_write(11'h2AA, 16'h0055);
        do_write(11'h555, 16'h0090);
        expect_read("R7 busy write ignored", 11'h000, 16'hFFFF);

        // R4: programming ANDs into the old word
        unlock(8'hA0);
        do_write(11'h005, 16'hFF0F);
        repeat (BUSY + 5) @(negedge clk);
        expect_read("R4 and", 11'h005, 16'h1204);

        // R5: wrong second cycle aborts the sequence
        do_write(11'h555, 16'h00AA);
        do_write(11'h2AB, 16'h0055);
        do_write(11'h555, 16'h00A0);
        do_write(11'h007, 16'h0000);
        repeat (BUSY + 5) @(negedge clk);
        expect_read("R5", 11'h007, 16'hFFFF);

        // R6: autoselect codes and exit
        unlock(8'h90);
        expect_read("R6 manuf", 11'h000, {8'h00, MAN});
        expect_read("R6 device", 11'h001, {8'h00, DEV});
        expect_read("R6 other", 11'h002, 16'h0000);
        do_write(11'h000, 16'h00F0);
        expect_read("R6 exit", 11'h000, 16'hFFFF);

        // R12: reset command in read-array and as third cycle
        do_write(11'h123, 16'h00F0);
        expect_read("R12 read", 11'h005, 16'h1204);
        unlock(8'hF0);
        do_write(11'h555, 16'h00A0);
        do_write(11'h008, 16'h0000);
        repeat (BUSY + 5) @(negedge clk);
        expect_read("R12 third", 11'h008, 16'hFFFF);

        // R9: bypass two-cycle program
        unlock(8'h20);
        do_write(11'h000, 16'h00A0);
        do_write(11'h009, 16'h00F0);
        do_read(11'h009, v);
        check("R8 bypass status", 32'(v), 32'({1'b1, 16'h0040}));
        repeat (BUSY + 5) @(negedge clk);
        expect_read("R9 first", 11'h009, 16'h00F0);
        do_write(11'h3FF, 16'h00A0);
        do_write(11'h00A, 16'h0F0F);
        repeat (BUSY + 5) @(negedge clk);
        expect_read("R9 stays bypass", 11'h00A, 16'h0F0F);

        // R10: incomplete exit stays in bypass, full exit leaves it
        do_write(11'h000, 16'h0090);
        do_write(11'h000, 16'h0055);
        do_write(11'h000, 16'h00A0);
        do_write(11'h00B, 16'h1111);
        repeat (BUSY + 5) @(negedge clk);
        expect_read("R10 stay", 11'h00B, 16'h1111);
        do_write(11'h000, 16'h0090);
        do_write(11'h000, 16'h0000);
        do_write(11'h000, 16'h00A0);
        do_write(11'h00C, 16'h0000);
        repeat (BUSY + 5) @(negedge clk);
        expect_read("R10 exit", 11'h00C, 16'hFFFF);

        // R3: we_n low with oe_n low is no write
        @(negedge clk); ce_n = 0; oe_n = 0; addr = 11'h555; dq_in = 16'h00AA; we_n = 0;
        @(negedge clk);
        check("R11 we low", {31'b0, dq_oe}, 32'd0);
        we_n = 1; oe_n = 1;
        @(negedge clk); ce_n = 1;
        do_write(11'h2AA, 16'h0055);
        do_write(11'h555, 16'h00A0);
        do_write(11'h00D, 16'h0000);
        repeat (BUSY + 5) @(negedge clk);
        expect_read("R3 oe low", 11'h00D, 16'hFFFF);

        // R3: long we_n low phase counts once
        @(negedge clk); ce_n = 0; oe_n = 1; addr = 11'h555; dq_in = 16'h00AA; we_n = 0;
        repeat (3) @(negedge clk);
        we_n = 1;
        @(negedge clk); ce_n = 1;
        do_write(11'h2AA, 16'h0055);
        do_write(11'h555, 16'h00A0);
        do_write(11'h00E, 16'h5555);
        repeat (BUSY + 5) @(negedge clk);
        expect_read("R3 long low", 11'h00E, 16'h5555);

        // R11: deselected with oe_n low
        @(negedge clk); ce_n = 1; oe_n = 0;
        @(negedge clk);
        check("R11 deselect", {15'b0, dq_oe, dq_out}, 32'd0);
        oe_n = 1;

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule